// File: doc/BRIEF.md
# Daisy-Chained SPI Channel Slave

This block is the serial control port of one channel in a chain of up to sixteen channels. All channels share chip select and serial clock. Each channel's data input is fed from the forwarded-data output of the channel before it. A transaction is three bytes long: a control byte, an address byte and a data byte. Chip select is raised after each byte, and that rising edge closes the byte.

While the control byte passes through, the channel subtracts one from the 4-bit channel identifier before it hands the byte on. It does this bit by bit, using a single borrow flag. The channel whose received identifier is zero is the target. When the broadcast flag is set, every bit passes through unchanged and every channel acts. The target writes a 256-entry byte register file, or it returns the addressed byte on SDO for a read. A separate enable output controls the SDO pad driver.

The serial inputs are synchronized to the block clock, and SCLK edges are found by oversampling. SCLK idles high. Input bits are sampled on rising SCLK edges and read data is driven on falling edges. Address and data go most significant bit first.

Top module: `chain_spi_slave`

## Requirements
- R1: The control byte is received in this order: broadcast flag (1 = all channels), access direction (1 = read, 0 = write), space select (0 = register file), one reserved bit, then the 4-bit channel ID, least significant bit first.
- R2: `sdi_thru_o` repeats `sdi_i` unchanged for the first four control bits and for every bit of the address and data bytes.
- R3: When broadcast is clear, the channel-ID bits go out on `sdi_thru_o` as the received ID minus one, modulo 16 (0 goes out as 15).
- R4: When broadcast is set, all eight control bits go out on `sdi_thru_o` unchanged.
- R5: A channel acts on a transaction only if its received ID is zero or broadcast is set. A write from a channel that is not the target leaves the register file unchanged.
- R6: A write by the target stores the data byte, received MSB first on rising SCLK edges, at the address given by the address byte.
- R7: A read by the target drives the addressed byte on `sdo_o`, MSB first, changing only on falling SCLK edges during the data byte, with `sdo_en_o` high.
- R8: `sdo_en_o` is low for writes, for channels that are not the target, for broadcast reads and whenever chip select is high.
- R9: The value on `sdi_i` during the data byte of a read does not change any register.
- R10: With space select set to 1, a write stores nothing and a read leaves `sdo_en_o` low.
- R11: A byte closed by chip select after any count of rising SCLK edges other than eight aborts the transaction. The next byte is taken as a control byte.
- R12: If chip select stays high for `IDLE_CYC` clocks, the next byte is taken as a control byte.
- R13: After reset, `sdo_en_o` is low and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock that oversamples the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Shared chip select, active low, raised after each byte |
| sclk_i | input | 1 | Shared serial clock, idle high |
| sdi_i | input | 1 | Serial data from the previous channel or the host |
| sdi_thru_o | output | 1 | Serial data forwarded to the next channel |
| sdo_o | output | 1 | Read data toward the host |
| sdo_en_o | output | 1 | Drive enable for the SDO pad (low means high impedance) |

## Verification
The bench sends identifiers of 3, 0 and 8 and compares the forwarded control byte bit by bit. A wrong borrow would stop at the first one bit too late or too early, so 8 would not become 7 and 0 would not wrap to 15. Writes addressed to other channels, broadcast writes, register-file writes with space select set, and reads that carry a noisy data byte are each read back. A design that ignored the identifier or space select, or that sampled SDI during a read, would return a changed register. Truncated bytes and a long chip-select pause are followed by full writes. A design without abort or idle recovery would mistake the next control byte for data and write to the wrong address. Broadcast reads and reads from channels that are not the target watch `sdo_en_o`, which a careless design would raise on a shared line.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;
  localparam int unsigned BYTE_W         = 8;
  localparam int unsigned CID_W          = 4;
  // slot index (order of arrival) where the channel ID starts
  localparam int unsigned CID_FIRST_SLOT = BYTE_W - CID_W;
  // positions in the shift register once a full control byte is in (first bit at MSB)
  localparam int unsigned POS_BCAST      = BYTE_W - 1;
  localparam int unsigned POS_RD         = BYTE_W - 2;
  localparam int unsigned POS_RAM        = BYTE_W - 3;

  typedef enum logic [1:0] {
    BYTE_CTRL = 2'd0,
    BYTE_ADDR = 2'd1,
    BYTE_DATA = 2'd2
  } byte_e;

  typedef struct packed {
    logic bcast;
    logic rd;
    logic ram;
    logic hit;
  } ctrl_t;
endpackage

// File: rtl/chain_spi_sync.sv
module chain_spi_sync #(
  parameter int unsigned     W       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/chain_spi_cid_fwd.sv
module chain_spi_cid_fwd
  import chain_spi_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_start_i,
  input  logic             sclk_rise_i,
  input  logic             sdi_s_i,
  input  logic             sdi_raw_i,
  input  logic             ctrl_byte_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  output logic             sdi_thru_o,
  output logic             cid_zero_o
);
  logic borrow_q;
  logic bcast_q;
  logic in_cid;

  assign in_cid = ctrl_byte_i
               && (bit_cnt_i >= CNT_W'(CID_FIRST_SLOT))
               && (bit_cnt_i <  CNT_W'(BYTE_W));

  // borrow stays set only while every ID bit seen so far was zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      borrow_q <= 1'b1;
      bcast_q  <= 1'b0;
    end else if (byte_start_i) begin
      borrow_q <= 1'b1;
      bcast_q  <= 1'b0;
    end else if (sclk_rise_i && ctrl_byte_i) begin
      if (bit_cnt_i == '0) bcast_q <= sdi_s_i;
      if (in_cid)          borrow_q <= borrow_q & ~sdi_s_i;
    end
  end

  assign sdi_thru_o = sdi_raw_i ^ (in_cid & ~bcast_q & borrow_q);
  assign cid_zero_o = borrow_q;
endmodule

// File: rtl/chain_spi_regfile.sv
module chain_spi_regfile #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/chain_spi_slave.sv
module chain_spi_slave
  import chain_spi_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned IDLE_CYC    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdi_thru_o,
  output logic sdo_o,
  output logic sdo_en_o
);
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 2);
  localparam int unsigned IDLE_W = $clog2(IDLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic cs_s, sclk_s, sdi_s;
  logic cs_d, sclk_d;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic byte_ok;

  chain_spi_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   ({cs_s, sclk_s, sdi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b1;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
  assign cs_rise   = cs_s & ~cs_d;
  assign cs_fall   = ~cs_s & cs_d;

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q  <= '0;
      shift_in_q <= '0;
    end else if (cs_s) begin
      bit_cnt_q  <= '0;
    end else if (sclk_rise) begin
      shift_in_q <= {shift_in_q[BYTE_W-2:0], sdi_s};
      if (bit_cnt_q != CNT_MAX) bit_cnt_q <= bit_cnt_q + 1'b1;
    end
  end

  assign byte_ok = (bit_cnt_q == CNT_W'(BYTE_W));

  byte_e              byte_idx_q;
  ctrl_t              ctrl_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [IDLE_W-1:0]  idle_cnt_q;
  logic               cid_zero;

  chain_spi_cid_fwd #(
    .CNT_W(CNT_W)
  ) u_cid_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .byte_start_i(cs_fall),
    .sclk_rise_i (sclk_rise),
    .sdi_s_i     (sdi_s),
    .sdi_raw_i   (sdi_i),
    .ctrl_byte_i (byte_idx_q == BYTE_CTRL),
    .bit_cnt_i   (bit_cnt_q),
    .sdi_thru_o  (sdi_thru_o),
    .cid_zero_o  (cid_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= '0;
    end else if (!cs_s) begin
      idle_cnt_q <= '0;
    end else if (idle_cnt_q != IDLE_W'(IDLE_CYC)) begin
      idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_idx_q <= BYTE_CTRL;
      ctrl_q     <= '0;
      addr_q     <= '0;
    end else if (cs_rise) begin
      if (!byte_ok) begin
        byte_idx_q <= BYTE_CTRL;
      end else begin
        unique case (byte_idx_q)
          BYTE_CTRL: begin
            ctrl_q.bcast <= shift_in_q[POS_BCAST];
            ctrl_q.rd    <= shift_in_q[POS_RD];
            ctrl_q.ram   <= shift_in_q[POS_RAM];
            ctrl_q.hit   <= shift_in_q[POS_BCAST] | cid_zero;
            byte_idx_q   <= BYTE_ADDR;
          end
          BYTE_ADDR: begin
            addr_q     <= shift_in_q[ADDR_W-1:0];
            byte_idx_q <= BYTE_DATA;
          end
          default: byte_idx_q <= BYTE_CTRL;
        endcase
      end
    end else if (idle_cnt_q == IDLE_W'(IDLE_CYC)) begin
      byte_idx_q <= BYTE_CTRL;
    end
  end

  logic              we;
  logic [BYTE_W-1:0] rdata;
  logic              drive;

  assign we = cs_rise && byte_ok && (byte_idx_q == BYTE_DATA)
           && ctrl_q.hit && !ctrl_q.rd && !ctrl_q.ram;

  chain_spi_regfile #(
    .AW(ADDR_W),
    .DW(BYTE_W)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .waddr_i(addr_q),
    .wdata_i(shift_in_q),
    .raddr_i(shift_in_q[ADDR_W-1:0]),
    .rdata_o(rdata)
  );

  // only a singly addressed target may drive the shared line
  assign drive = (byte_idx_q == BYTE_DATA) && ctrl_q.hit && ctrl_q.rd
              && !ctrl_q.ram && !ctrl_q.bcast;

  logic [BYTE_W-1:0] out_sh_q;
  logic              sdo_q;
  logic              sdo_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sh_q <= '0;
      sdo_q    <= 1'b0;
      sdo_en_q <= 1'b0;
    end else if (cs_s) begin
      sdo_en_q <= 1'b0;
      // preload read data as the address byte closes
      if (cs_rise && byte_ok && byte_idx_q == BYTE_ADDR) out_sh_q <= rdata;
    end else if (sclk_fall && drive) begin
      sdo_en_q <= 1'b1;
      sdo_q    <= out_sh_q[BYTE_W-1];
      out_sh_q <= {out_sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign sdo_o    = sdo_q;
  assign sdo_en_o = sdo_en_q;
endmodule

// File: rtl/chain_spi_slave_chk.sv
module chain_spi_slave_chk #(
  parameter int unsigned IDLE_CYC = 64,
  parameter int unsigned IW       = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sdo_o,
  input logic          sdo_en_o,
  input logic [1:0]    byte_idx,
  input logic          bcast_q,
  input logic          ram_q,
  input logic          sclk_fall,
  input logic          cs_s,
  input logic [IW-1:0] idle_cnt
);
  AST_EN_IN_DATA_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en_o |-> (byte_idx == 2'd2)); // R7

  AST_SDO_ON_FALL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(sdo_o)); // R7

  AST_EN_NO_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en_o |-> !bcast_q); // R8

  AST_EN_DROP_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdo_en_o); // R8

  AST_EN_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en_o |-> !ram_q); // R10

  AST_IDLE_REFRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt == IW'(IDLE_CYC)) |=> (byte_idx == 2'd0)); // R12
endmodule

bind chain_spi_slave chain_spi_slave_chk #(
  .IDLE_CYC(IDLE_CYC),
  .IW      (IDLE_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sdo_o    (sdo_o),
  .sdo_en_o (sdo_en_o),
  .byte_idx (byte_idx_q),
  .bcast_q  (ctrl_q.bcast),
  .ram_q    (ctrl_q.ram),
  .sclk_fall(sclk_fall),
  .cs_s     (cs_s),
  .idle_cnt (idle_cnt_q)
);

// File: tb/chain_spi_slave_bench.sv
`timescale 1ns/1ps
module chain_spi_slave_bench;
  localparam int H    = 8;   // clocks per SCLK half period
  localparam int GAP  = 12;  // clocks CS high between bytes
  localparam int IDLE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b1, sdi = 1'b0;
  logic sdi_thru, sdo, sdo_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chain_spi_slave u_chain_spi_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdi_thru_o(sdi_thru), .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ctl(input bit bc, input bit rd, input bit ram, input logic [3:0] cid);
    return {bc, rd, ram, 1'b0, cid[0], cid[1], cid[2], cid[3]};
  endfunction

  task automatic send_bits(input logic [7:0] v, input int n, output logic [7:0] thru,
                           output logic [7:0] so, output bit en_all, output bit en_any);
    thru = '0; so = '0; en_all = 1; en_any = 0;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; sdi = v[7-i];
      repeat (H) @(negedge clk);
      thru[7-i] = sdi_thru; so[7-i] = sdo;
      en_all &= sdo_en; en_any |= sdo_en;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic xfer(input bit bc, input bit rd, input bit ram, input logic [3:0] cid,
                      input logic [7:0] addr, input logic [7:0] data,
                      output logic [23:0] thru, output logic [7:0] rb,
                      output bit en_all, output bit en_any);
    logic [7:0] t, s; bit ea, ey;
    send_bits(ctl(bc, rd, ram, cid), 8, t, s, ea, ey); thru[23:16] = t; en_any = ey;
    send_bits(addr, 8, t, s, ea, ey);                 thru[15:8]  = t; en_any |= ey;
    send_bits(data, 8, t, s, ea, ey);                 thru[7:0]   = t; en_any |= ey;
    rb = s; en_all = ea;
  endtask

  task automatic wr(input logic [3:0] cid, input logic [7:0] a, input logic [7:0] d);
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    xfer(0, 0, 0, cid, a, d, t, r, ea, ey);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    xfer(0, 1, 0, 4'd0, a, 8'h00, t, r, ea, ey);
    chk(r == exp, req, "read data", {24'd0, r}, {24'd0, exp});
    chk(ea, "R7", "sdo_en during read", {31'd0, ea}, 32'd1);
  endtask

  task automatic t_reset;
    chk(sdo_en == 1'b0, "R13", "sdo_en after reset", {31'd0, sdo_en}, 32'd0);
    rd_chk(8'h05, 8'h00, "R13");
  endtask

  task automatic t_write_read;
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    xfer(0, 0, 0, 4'd0, 8'h00, 8'hA5, t, r, ea, ey);
    chk(!ey, "R8", "sdo_en during write", {31'd0, ey}, 32'd0);
    wr(4'd0, 8'hFF, 8'h3C);
    wr(4'd0, 8'h10, 8'h81);
    rd_chk(8'h00, 8'hA5, "R6");
    rd_chk(8'hFF, 8'h3C, "R6");
    rd_chk(8'h10, 8'h81, "R7");
  endtask

  task automatic t_forward;
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    xfer(0, 0, 0, 4'd3, 8'h6B, 8'hD2, t, r, ea, ey);
    chk(t[23:16] == ctl(0, 0, 0, 4'd2), "R3", "ID 3 forwarded", {24'd0, t[23:16]}, {24'd0, ctl(0, 0, 0, 4'd2)});
    chk(t[15:8] == 8'h6B, "R2", "address forwarded", {24'd0, t[15:8]}, 32'h6B);
    chk(t[7:0] == 8'hD2, "R2", "data forwarded", {24'd0, t[7:0]}, 32'hD2);
    xfer(0, 1, 1, 4'd0, 8'h01, 8'h00, t, r, ea, ey);
    chk(t[23:16] == ctl(0, 1, 1, 4'd15), "R3", "ID 0 wraps to 15", {24'd0, t[23:16]}, {24'd0, ctl(0, 1, 1, 4'd15)});
    chk(t[23:20] == 4'b0110, "R2", "flag slots unchanged", {28'd0, t[23:20]}, 32'h6);
    xfer(0, 1, 0, 4'd8, 8'h02, 8'h00, t, r, ea, ey);
    chk(t[23:16] == ctl(0, 1, 0, 4'd7), "R1", "ID 8 forwarded LSB first as 7", {24'd0, t[23:16]}, {24'd0, ctl(0, 1, 0, 4'd7)});
  endtask

  task automatic t_nontarget;
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    wr(4'd1, 8'h10, 8'h77);
    rd_chk(8'h10, 8'h81, "R5");
    xfer(0, 1, 0, 4'd2, 8'h10, 8'h00, t, r, ea, ey);
    chk(!ey, "R8", "non-target read sdo_en", {31'd0, ey}, 32'd0);
  endtask

  task automatic t_bcast;
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    xfer(1, 0, 0, 4'd5, 8'h20, 8'h5A, t, r, ea, ey);
    chk(t[23:16] == ctl(1, 0, 0, 4'd5), "R4", "broadcast control unchanged", {24'd0, t[23:16]}, {24'd0, ctl(1, 0, 0, 4'd5)});
    rd_chk(8'h20, 8'h5A, "R5");
    xfer(1, 1, 0, 4'd0, 8'h20, 8'h00, t, r, ea, ey);
    chk(!ey, "R8", "broadcast read sdo_en", {31'd0, ey}, 32'd0);
  endtask

  task automatic t_ram;
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    xfer(0, 0, 1, 4'd0, 8'h00, 8'hEE, t, r, ea, ey);
    rd_chk(8'h00, 8'hA5, "R10");
    xfer(0, 1, 1, 4'd0, 8'h00, 8'h00, t, r, ea, ey);
    chk(!ey, "R10", "space-select read sdo_en", {31'd0, ey}, 32'd0);
  endtask

  task automatic t_sdi_ignored;
    logic [23:0] t; logic [7:0] r; bit ea, ey;
    xfer(0, 1, 0, 4'd0, 8'hFF, 8'h96, t, r, ea, ey);
    chk(r == 8'h3C, "R9", "read with noisy SDI", {24'd0, r}, 32'h3C);
    rd_chk(8'hFF, 8'h3C, "R9");
  endtask

  task automatic t_abort;
    logic [7:0] t, s; bit ea, ey;
    send_bits(ctl(0, 0, 0, 4'd0), 8, t, s, ea, ey);
    send_bits(8'h40, 8, t, s, ea, ey);
    send_bits(8'hC3, 4, t, s, ea, ey);
    wr(4'd0, 8'h41, 8'h99);
    rd_chk(8'h40, 8'h00, "R11");
    rd_chk(8'h41, 8'h99, "R11");
    send_bits(ctl(0, 0, 0, 4'd0), 5, t, s, ea, ey);
    wr(4'd0, 8'h42, 8'h66);
    rd_chk(8'h42, 8'h66, "R11");
  endtask

  task automatic t_idle;
    logic [7:0] t, s; bit ea, ey;
    send_bits(ctl(0, 0, 0, 4'd0), 8, t, s, ea, ey);
    send_bits(8'h50, 8, t, s, ea, ey);
    repeat (IDLE + 20) @(negedge clk);
    wr(4'd0, 8'h51, 8'h42);
    rd_chk(8'h51, 8'h42, "R12");
    rd_chk(8'h50, 8'h00, "R12");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_read();
    t_forward();
    t_nontarget();
    t_bcast();
    t_ram();
    t_sdi_ignored();
    t_abort();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule